// File: doc/BRIEF.md
# RTC Alarm Comparator with Wildcard Fields

This block holds the alarm bytes for seconds, minutes and hours of a real-time clock and checks them against the running time. The check happens only in the cycle where the time counter reports that an update has just finished. If every field matches, a sticky alarm flag is set. An alarm byte whose two top bits are both 1 is a wildcard, so that field matches any time value. This makes alarms such as "every minute at second 30" or "once a second" possible.

Software reaches the three alarm bytes and a flag byte through a small byte bus. The read data path is combinational. Reading the flag byte returns the flag and clears it.

The comparison is a plain bitwise equality on the stored encodings. Each alarm byte therefore records the data mode (BCD or binary) that was active when it was written. A field written in one mode never matches while the clock runs in the other mode, unless that field is a wildcard.

The interrupt request is the flag gated by the alarm enable. The enable only counts while the clock-valid input is high.

Top module: `rtc_alarm_match`

## Requirements
- R1: Bus address 0 holds the seconds alarm byte, address 1 the minutes alarm byte and address 2 the hours alarm byte. A write stores the byte, and a later read at the same address returns it. All three bytes reset to 0x00. Address 3 reads the flag byte: bit 0 is the alarm flag and bits 7:1 read 0.
- R2: When `updateDone` is 1 in a cycle and all three fields match in that cycle, `alarmFlag` is 1 from the next clock edge.
- R3: An alarm byte with bits 7:6 equal to 2'b11 matches any time value, in either data mode, whatever its low six bits are.
- R4: A non-wildcard alarm byte matches only if it is bitwise equal to its time field, including bit 7 of the hours byte (the PM marker). A byte that differs in any bit does not match.
- R5: Every alarm byte records `dataModeBin` (1 = binary, 0 = BCD) when it is written. A non-wildcard byte whose recorded mode differs from the current `dataModeBin` never matches.
- R6: No comparison happens while `updateDone` is 0. A matching time presented without the strobe leaves `alarmFlag` unchanged.
- R7: `alarmFlag` is set whether or not the interrupt is enabled, and it stays set through later non-matching updates. A read of address 3 (with `busRe` = 1) returns the flag and clears it at the next edge. If a new match arrives in the same cycle as the clearing read, the set wins.
- R8: `alarmIrq` is 1 exactly when `alarmFlag`, `alarmEnIn` and `rtcValid` are all 1. It is 0 whenever `rtcValid` is 0.
- R9: After reset, `alarmFlag` and `alarmIrq` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| busWe | input | 1 | Write strobe for the byte bus |
| busRe | input | 1 | Read strobe for the byte bus (a read of address 3 clears the flag) |
| busAddr | input | 2 | Register address |
| busWdata | input | 8 | Write data |
| busRdata | output | 8 | Read data, combinational from `busAddr` |
| timeSec | input | 8 | Current seconds value |
| timeMin | input | 8 | Current minutes value |
| timeHour | input | 8 | Current hours value, with bit 7 as the PM marker in 12-hour mode |
| updateDone | input | 1 | One-cycle strobe: the time update has just completed |
| dataModeBin | input | 1 | Data mode: 1 = binary, 0 = BCD |
| alarmEnIn | input | 1 | Alarm interrupt enable |
| rtcValid | input | 1 | Clock valid; when 0 it forces the enable off |
| alarmFlag | output | 1 | Sticky alarm flag |
| alarmIrq | output | 1 | Alarm interrupt request |

## Verification
- The flag is registered. It is therefore due one edge after the cycle in which `updateDone` is high.
- The bench raises the strobe at a falling edge, drops it at the next falling edge and reads the flag there.
- Read data and the interrupt request are combinational. They are sampled a short delay after their inputs change, still before the following rising edge.
- A clearing read takes effect at the edge that ends the read cycle, so the flag is checked at the falling edge after that.

// File: rtl/rtc_alarm_pkg.sv
package rtc_alarm_pkg;
  // Number of compared alarm fields (seconds, minutes, hours).
  localparam int FIELD_COUNT = 3;
  localparam int BYTE_W      = 8;
  localparam int ADDR_W      = $clog2(FIELD_COUNT + 1);
  localparam logic [ADDR_W-1:0] FLAG_ADDR = ADDR_W'(FIELD_COUNT);
  localparam logic [1:0] WILD_CODE = 2'b11;

  // Strobes from control to datapath.
  typedef struct packed {
    logic              wrEn;
    logic [ADDR_W-1:0] wrIdx;
    logic              rdFlags;
    logic              evalNow;
    logic              irqGate;
  } ctrl_t;
endpackage

// File: rtl/rtc_alarm_ctrl.sv
module rtc_alarm_ctrl
  import rtc_alarm_pkg::*;
(
  input  logic              busWe,
  input  logic              busRe,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              updateDone,
  input  logic              alarmEnIn,
  input  logic              rtcValid,
  output ctrl_t             ctrl
);
  logic addrIsField;
  logic addrIsFlag;

  assign addrIsField = busAddr < ADDR_W'(FIELD_COUNT);
  assign addrIsFlag  = busAddr == FLAG_ADDR;

  always_comb begin
    ctrl         = '0;
    ctrl.wrEn    = busWe && addrIsField;
    ctrl.wrIdx   = busAddr;
    ctrl.rdFlags = busRe && addrIsFlag;
    ctrl.evalNow = updateDone;
    // Enable is only honoured while the clock reports valid.
    ctrl.irqGate = alarmEnIn && rtcValid;
  end
endmodule

// File: rtl/rtc_alarm_dp.sv
module rtc_alarm_dp
  import rtc_alarm_pkg::*;
(
  input  logic                          clk,
  input  logic                          rstN,
  input  ctrl_t                         ctrl,
  input  logic [BYTE_W-1:0]             wrData,
  input  logic [ADDR_W-1:0]             rdAddr,
  input  logic [FIELD_COUNT*BYTE_W-1:0] timeNow,
  input  logic                          modeBin,
  output logic [BYTE_W-1:0]             rdData,
  output logic                          flag,
  output logic                          irq
);
  logic [FIELD_COUNT-1:0][BYTE_W-1:0] alarmView;
  logic [FIELD_COUNT-1:0]             fieldHit;
  logic                               allHit;

  generate
    for (genvar i = 0; i < FIELD_COUNT; i++) begin : g_field
      logic [BYTE_W-1:0] alarmQ;
      logic              tagQ;
      logic              isWild;
      logic              exactHit;

      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) begin
          alarmQ <= '0;
          tagQ   <= 1'b0;
        end else if (ctrl.wrEn && ctrl.wrIdx == ADDR_W'(i)) begin
          alarmQ <= wrData;
          tagQ   <= modeBin;
        end
      end

      assign isWild   = alarmQ[BYTE_W-1 -: 2] == WILD_CODE;
      assign exactHit = (tagQ == modeBin) &&
                        (alarmQ == timeNow[i*BYTE_W +: BYTE_W]);
      assign fieldHit[i]  = isWild || exactHit;
      assign alarmView[i] = alarmQ;
    end
  endgenerate

  assign allHit = &fieldHit;

  // Set has priority over the clearing read.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)
      flag <= 1'b0;
    else if (ctrl.evalNow && allHit)
      flag <= 1'b1;
    else if (ctrl.rdFlags)
      flag <= 1'b0;
  end

  always_comb begin
    rdData = '0;
    if (rdAddr == FLAG_ADDR)
      rdData[0] = flag;
    for (int i = 0; i < FIELD_COUNT; i++)
      if (rdAddr == ADDR_W'(i))
        rdData = alarmView[i];
  end

  assign irq = flag && ctrl.irqGate;
endmodule

// File: rtl/rtc_alarm_match.sv
module rtc_alarm_match
  import rtc_alarm_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              busWe,
  input  logic              busRe,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [BYTE_W-1:0] busWdata,
  output logic [BYTE_W-1:0] busRdata,
  input  logic [BYTE_W-1:0] timeSec,
  input  logic [BYTE_W-1:0] timeMin,
  input  logic [BYTE_W-1:0] timeHour,
  input  logic              updateDone,
  input  logic              dataModeBin,
  input  logic              alarmEnIn,
  input  logic              rtcValid,
  output logic              alarmFlag,
  output logic              alarmIrq
);
  ctrl_t ctrl;
  logic [FIELD_COUNT*BYTE_W-1:0] timeNow;

  assign timeNow = {timeHour, timeMin, timeSec};

  rtc_alarm_ctrl u_ctrl (
    .busWe      (busWe),
    .busRe      (busRe),
    .busAddr    (busAddr),
    .updateDone (updateDone),
    .alarmEnIn  (alarmEnIn),
    .rtcValid   (rtcValid),
    .ctrl       (ctrl)
  );

  rtc_alarm_dp u_dp (
    .clk     (clk),
    .rstN    (rstN),
    .ctrl    (ctrl),
    .wrData  (busWdata),
    .rdAddr  (busAddr),
    .timeNow (timeNow),
    .modeBin (dataModeBin),
    .rdData  (busRdata),
    .flag    (alarmFlag),
    .irq     (alarmIrq)
  );
endmodule

// File: rtl/rtc_alarm_match_chk.sv
module rtc_alarm_match_chk
  import rtc_alarm_pkg::*;
(
  input logic              clk,
  input logic              rstN,
  input logic              busRe,
  input logic [ADDR_W-1:0] busAddr,
  input logic              updateDone,
  input logic              alarmEnIn,
  input logic              rtcValid,
  input logic              alarmFlag,
  input logic              alarmIrq
);
  logic flagRead;
  assign flagRead = busRe && busAddr == FLAG_ADDR;

  // R2 / R6: the flag only rises after an update strobe
  a_r6_rise_needs_update: assert property (@(posedge clk) disable iff (!rstN)
    $rose(alarmFlag) |-> $past(updateDone));

  // R8: no request without valid clock and enable
  a_r8_irq_gated: assert property (@(posedge clk) disable iff (!rstN)
    (!rtcValid || !alarmEnIn) |-> !alarmIrq);

  // R8: no request without the flag
  a_r8_irq_needs_flag: assert property (@(posedge clk) disable iff (!rstN)
    alarmIrq |-> alarmFlag);

  // R7: a clearing read with no strobe empties the flag
  a_r7_read_clears: assert property (@(posedge clk) disable iff (!rstN)
    (flagRead && !updateDone) |=> !alarmFlag);

  // R7: the flag holds when neither set nor cleared
  a_r7_flag_sticky: assert property (@(posedge clk) disable iff (!rstN)
    (!updateDone && !flagRead) |=> $stable(alarmFlag));
endmodule

bind rtc_alarm_match rtc_alarm_match_chk u_chk (
  .clk        (clk),
  .rstN       (rstN),
  .busRe      (busRe),
  .busAddr    (busAddr),
  .updateDone (updateDone),
  .alarmEnIn  (alarmEnIn),
  .rtcValid   (rtcValid),
  .alarmFlag  (alarmFlag),
  .alarmIrq   (alarmIrq)
);

// File: tb/tb_rtc_alarm_match.sv
`timescale 1ns/1ps
module tb_rtc_alarm_match;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic busWe = 1'b0, busRe = 1'b0;
  logic [1:0] busAddr = '0;
  logic [7:0] busWdata = '0;
  logic [7:0] busRdata;
  logic [7:0] timeSec = '0, timeMin = '0, timeHour = '0;
  logic updateDone = 1'b0, dataModeBin = 1'b0, alarmEnIn = 1'b0, rtcValid = 1'b0;
  logic alarmFlag, alarmIrq;

  int checks = 0;
  int fails = 0;
  bit done = 0;
  logic [7:0] rdVal;

  always #10 clk = ~clk;

  rtc_alarm_match dut (.*);

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic busWrite(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk); busWe = 1'b1; busAddr = a; busWdata = d;
    @(negedge clk); busWe = 1'b0;
  endtask

  task automatic busRead(input logic [1:0] a);
    @(negedge clk); busRe = 1'b1; busAddr = a;
    #1 rdVal = busRdata;
    @(negedge clk); busRe = 1'b0;
  endtask

  task automatic doUpdate(input logic [7:0] s, input logic [7:0] m, input logic [7:0] h);
    @(negedge clk); timeSec = s; timeMin = m; timeHour = h; updateDone = 1'b1;
    @(negedge clk); updateDone = 1'b0;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    logic [7:0] tv [3];
    tv[0] = 8'h45; tv[1] = 8'h37; tv[2] = 8'h92;
    repeat (3) @(negedge clk);
    // R9 reset state
    chk(alarmFlag == 1'b0, "R9 flag after reset", alarmFlag, 0);
    chk(alarmIrq == 1'b0, "R9 irq after reset", alarmIrq, 0);
    rstN = 1'b1;
    // R1 reset values and flag byte
    for (int a = 0; a < 4; a++) begin
      busRead(2'(a));
      chk(rdVal == 8'h00, "R1 reset readback", rdVal, 0);
    end
    // R1 write/readback sweep
    for (int a = 0; a < 3; a++)
      for (int p = 0; p < 4; p++) begin
        logic [7:0] pat;
        pat = (p == 0) ? 8'h00 : (p == 1) ? 8'hFF : (p == 2) ? 8'h5A : 8'hA5;
        busWrite(2'(a), pat);
        busRead(2'(a));
        chk(rdVal == pat, "R1 alarm byte readback", rdVal, pat);
      end

    // R2/R3/R4/R5/R7/R8 sweep over all field kinds
    for (int c = 0; c < 64; c++) begin
      bit expHit;
      bit expIrq;
      expHit = 1'b1;
      for (int f = 0; f < 3; f++) begin
        int k;
        logic [7:0] v;
        k = (c >> (2 * f)) & 3;
        dataModeBin = (k == 3);
        case (k)
          0: v = tv[f];
          1: v = tv[f] ^ 8'h01;
          2: v = 8'hC0 | 8'(c & 63);
          default: v = tv[f];
        endcase
        busWrite(2'(f), v);
        if (k == 1 || k == 3) expHit = 1'b0;
      end
      dataModeBin = 1'b0;
      alarmEnIn = (c % 3) != 0;
      rtcValid = (c % 5) != 0;
      doUpdate(tv[0], tv[1], tv[2]);
      chk(alarmFlag == expHit, "R2 R3 R4 R5 flag after update", alarmFlag, expHit);
      expIrq = expHit && alarmEnIn && rtcValid;
      chk(alarmIrq == expIrq, "R8 irq gating", alarmIrq, expIrq);
      busRead(2'd3);
      chk(rdVal == {7'b0, expHit}, "R7 R1 flag byte read", rdVal, expHit);
      chk(alarmFlag == 1'b0, "R7 cleared by read", alarmFlag, 0);
    end

    // R3 wildcard low-bit sweep in both modes
    for (int k = 0; k < 64; k++) begin
      dataModeBin = k[0];
      for (int f = 0; f < 3; f++) busWrite(2'(f), 8'hC0 | 8'(k));
      dataModeBin = ~k[0];
      doUpdate(8'(k * 7), 8'(k * 13 + 5), 8'(k * 29 + 1));
      chk(alarmFlag == 1'b1, "R3 wildcard matches", alarmFlag, 1);
      busRead(2'd3);
    end

    // R5 mode tag: write mode vs compare mode
    for (int wm = 0; wm < 2; wm++)
      for (int cm = 0; cm < 2; cm++) begin
        bit e;
        dataModeBin = wm[0];
        for (int f = 0; f < 3; f++) busWrite(2'(f), tv[f]);
        dataModeBin = cm[0];
        doUpdate(tv[0], tv[1], tv[2]);
        e = (wm == cm);
        chk(alarmFlag == e, "R5 mode tag compare", alarmFlag, e);
        busRead(2'd3);
      end
    dataModeBin = 1'b0;

    // R6 no strobe means no compare
    for (int f = 0; f < 3; f++) busWrite(2'(f), tv[f]);
    @(negedge clk); timeSec = tv[0]; timeMin = tv[1]; timeHour = tv[2];
    repeat (5) @(negedge clk);
    chk(alarmFlag == 1'b0, "R6 no compare without strobe", alarmFlag, 0);
    doUpdate(tv[0], tv[1], tv[2]);
    chk(alarmFlag == 1'b1, "R6 compare with strobe", alarmFlag, 1);

    // R7 sticky across non-matching update, enable off
    alarmEnIn = 1'b0; rtcValid = 1'b1;
    doUpdate(8'h00, 8'h00, 8'h00);
    chk(alarmFlag == 1'b1, "R7 sticky over mismatch", alarmFlag, 1);
    chk(alarmIrq == 1'b0, "R8 irq off when disabled", alarmIrq, 0);

    // R8 combinational gating with flag set
    for (int g = 0; g < 4; g++) begin
      bit e;
      @(negedge clk); alarmEnIn = g[0]; rtcValid = g[1];
      #1 e = g[0] && g[1];
      chk(alarmIrq == e, "R8 irq truth table", alarmIrq, e);
    end

    // R7 set wins over simultaneous clearing read
    @(negedge clk); busRe = 1'b1; busAddr = 2'd3; updateDone = 1'b1;
    timeSec = tv[0]; timeMin = tv[1]; timeHour = tv[2];
    @(negedge clk); busRe = 1'b0; updateDone = 1'b0;
    chk(alarmFlag == 1'b1, "R7 set wins over clear", alarmFlag, 1);
    busRead(2'd3);
    chk(alarmFlag == 1'b0, "R7 later read clears", alarmFlag, 0);

    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule